// File: doc/BRIEF.md
# Strong Pullup and Programming Pulse Controller

This block drives one of two pulse enables for a single-wire bus master: a strong pullup enable to the supply rail, or a programming-voltage enable. A one-cycle start strobe carries the pulse type and a 3-bit duration code. The selected enable rises on the next clock and stays high for a predefined number of microsecond ticks. Some codes mean no time limit, and then only a host stop strobe ends the pulse. When a pulse ends, for any reason, a one-cycle completion strobe is raised so the surrounding command logic can send its response.

A start can also be given in armed form. In that case the block records the pulse type and duration but keeps both enables low. It waits for a fire strobe from the bit-slot logic before it begins the pulse, and a host stop strobe given while it waits cancels the pulse. The predefined lengths follow fixed formulas that are scaled by parameters. A strong pullup lasts `PU_UNIT << code` ticks. A programming pulse lasts `PP_UNIT * (code+1)` ticks.

Top module: `pullup_pulse_ctrl`

## Requirements
- R1: After reset, `pullup_on`, `prog_on`, `armed` and `done` are all 0.
- R2: When the block is idle and `start` is 1 with `arm` 0, the selected enable is 1 on the next cycle. `sel_prog`=0 selects `pullup_on` and `sel_prog`=1 selects `prog_on`. The other enable stays 0.
- R3: A strong pullup (`sel_prog`=0) with code 0 to 5 stays high while exactly `PU_UNIT << code` rising-edge `us_tick` samples are taken. The count starts with the first sample after the enable rises.
- R4: A programming pulse (`sel_prog`=1) with code 0 to 6 stays high while exactly `PP_UNIT*(code+1)` `us_tick` samples are taken.
- R5: A strong pullup with code 6 or 7, or a programming pulse with code 7, has no time limit. It ends only on the cycle after `host_stop`.
- R6: `done` is a one-cycle strobe. It is 1 in exactly the cycle in which the enable first reads 0 after a pulse, and it occurs once per pulse.
- R7: A `host_stop` during a timed pulse ends that pulse on the next cycle and still produces `done`.
- R8: `pullup_on` and `prog_on` are never 1 at the same time.
- R9: A `start` while a pulse is active is ignored: the enable, its type and the remaining duration do not change.
- R10: `start` with `arm`=1 sets `armed` on the next cycle and keeps both enables 0, even while ticks arrive. The cycle after `fire`, the pulse begins with its full duration and `armed` drops.
- R11: `host_stop` while armed clears `armed` on the next cycle. No enable rises and no `done` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle strobe, once per microsecond |
| start | input | 1 | Pulse command strobe |
| sel_prog | input | 1 | Pulse type: 0 strong pullup, 1 programming pulse |
| code | input | 3 | Duration code |
| arm | input | 1 | With start: wait for fire before pulsing |
| fire | input | 1 | Begins an armed pulse |
| host_stop | input | 1 | Host terminate strobe |
| pullup_on | output | 1 | Strong pullup enable |
| prog_on | output | 1 | Programming pulse enable |
| armed | output | 1 | Command held, waiting for fire |
| done | output | 1 | Completion strobe |

## Verification
Every result appears one register stage after the edge that samples its cause. An enable rises in the cycle after `start` or `fire`, and it falls together with `done` in the cycle after the final tick or `host_stop`. The bench drives inputs and samples outputs at falling edges. It changes `us_tick` shortly after each rising edge, so each falling-edge sample shows exactly what the next rising edge will consume. Durations are checked by counting ticks seen at falling edges while the enable is high, and comparing that count with the formula for every code of both pulse types.

// File: rtl/pullup_pulse_ctrl.sv
module pullup_pulse_ctrl #(
  parameter int CNT_W   = 16,
  parameter int PU_UNIT = 16,
  parameter int PP_UNIT = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       start,
  input  logic       sel_prog,
  input  logic [2:0] code,
  input  logic       arm,
  input  logic       fire,
  input  logic       host_stop,
  output logic       pullup_on,
  output logic       prog_on,
  output logic       armed,
  output logic       done
);

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_PULSE} state_t;

  state_t           state;
  logic             kind_q;
  logic             inf_q;
  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] dur_of(input logic p, input logic [2:0] c);
    if (p) return CNT_W'(PP_UNIT * (int'(c) + 1));
    else   return CNT_W'(PU_UNIT << c);
  endfunction

  wire req_inf  = sel_prog ? (code == 3'd7) : (code >= 3'd6);
  wire last_tk  = !inf_q && us_tick && (cnt == CNT_W'(1));
  wire finish   = (state == S_PULSE) && (host_stop || last_tk);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      kind_q <= 1'b0;
      inf_q  <= 1'b0;
      cnt    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          kind_q <= sel_prog;
          inf_q  <= req_inf;
          cnt    <= dur_of(sel_prog, code);
          state  <= arm ? S_ARMED : S_PULSE;
        end
        S_ARMED: begin
          if (host_stop)  state <= S_IDLE;
          else if (fire)  state <= S_PULSE;
        end
        S_PULSE: begin
          if (finish) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else if (us_tick && !inf_q) begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign pullup_on = (state == S_PULSE) && !kind_q;
  assign prog_on   = (state == S_PULSE) &&  kind_q;
  assign armed     = (state == S_ARMED);

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pullup_on && prog_on));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start && !arm) |=> (pullup_on != prog_on));

  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pullup_on || prog_on) && host_stop) |=> (done && !pullup_on && !prog_on));

  p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(state) == S_PULSE && !pullup_on && !prog_on));

  p_done_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PULSE && !inf_q) |-> (cnt != '0));

  p_arm_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && host_stop) |=> (!armed && !done && !pullup_on && !prog_on));

endmodule

// File: tb/test_pullup_pulse_ctrl.sv
module test_pullup_pulse_ctrl;
  localparam int PU = 2;
  localparam int PP = 3;

  logic clk = 0, rst_n = 0, us_tick = 0, start = 0, sel_prog = 0, arm = 0, fire = 0, host_stop = 0;
  logic [2:0] code = 0;
  logic pullup_on, prog_on, armed, done;
  int checks = 0, errors = 0;
  int tdiv = 0;

  pullup_pulse_ctrl #(.CNT_W(12), .PU_UNIT(PU), .PP_UNIT(PP)) i_pullup_pulse_ctrl (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start(start), .sel_prog(sel_prog),
    .code(code), .arm(arm), .fire(fire), .host_stop(host_stop),
    .pullup_on(pullup_on), .prog_on(prog_on), .armed(armed), .done(done));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    #2;
    tdiv = (tdiv + 1) % 4;
    us_tick = (tdiv == 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_dur(input bit p, input int c);
    return p ? PP * (c + 1) : (PU << c);
  endfunction

  function automatic bit is_inf(input bit p, input int c);
    return p ? (c == 7) : (c >= 6);
  endfunction

  task automatic issue(input bit p, input int c, input bit a);
    sel_prog = p; code = 3'(c); arm = a; start = 1;
    @(negedge clk);
    start = 0; arm = 0;
  endtask

  task automatic timed(input bit p, input int c, input bit poke);
    int n = 0;
    int guard = 0;
    int want = exp_dur(p, c);
    bit on;
    chk((p ? prog_on : pullup_on) && !(p ? pullup_on : prog_on), "R2", {30'd0, pullup_on, prog_on}, p ? 1 : 2);
    forever begin
      on = p ? prog_on : pullup_on;
      if (!on || guard > 2000) break;
      chk(!(pullup_on && prog_on), "R8", {30'd0, pullup_on, prog_on}, p ? 1 : 2);
      if (us_tick) n++;
      if (poke && guard == 3) begin
        start = 1; sel_prog = !p; code = 3'd0;
      end
      @(negedge clk);
      start = 0;
      if (poke && guard == 3) chk((p ? prog_on : pullup_on) || n == want, "R9", n, want);
      guard++;
    end
    chk(n == want, p ? "R4" : "R3", n, want);
    chk(done == 1, "R6", done, 1);
    @(negedge clk);
    chk(done == 0, "R6", done, 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({pullup_on, prog_on, armed, done} == 4'b0, "R1", {pullup_on, prog_on, armed, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({pullup_on, prog_on, armed, done} == 4'b0, "R1", {pullup_on, prog_on, armed, done}, 0);

    // R3 R4: every timed code of both types
    for (int p = 0; p < 2; p++)
      for (int c = 0; c < 8; c++)
        if (!is_inf(p[0], c)) begin
          issue(p[0], c, 0);
          timed(p[0], c, 0);
          repeat (2) @(negedge clk);
        end

    // R5: every unlimited code
    for (int p = 0; p < 2; p++)
      for (int c = 0; c < 8; c++)
        if (is_inf(p[0], c)) begin
          issue(p[0], c, 0);
          repeat (300) @(negedge clk);
          chk(p ? prog_on : pullup_on, "R5", p ? prog_on : pullup_on, 1);
          chk(done == 0, "R5", done, 0);
          host_stop = 1;
          @(negedge clk);
          host_stop = 0;
          chk(!pullup_on && !prog_on, "R5", {pullup_on, prog_on}, 0);
          chk(done == 1, "R6", done, 1);
          @(negedge clk);
          chk(done == 0, "R6", done, 0);
        end

    // R7: early stop of a timed pulse
    issue(0, 5, 0);
    repeat (10) @(negedge clk);
    chk(pullup_on, "R7", pullup_on, 1);
    host_stop = 1;
    @(negedge clk);
    host_stop = 0;
    chk(!pullup_on && done, "R7", {pullup_on, done}, 1);
    @(negedge clk);

    // R9: start while busy ignored
    issue(1, 2, 0);
    timed(1, 2, 1);
    issue(0, 3, 0);
    timed(0, 3, 1);

    // R10: armed then fired
    for (int p = 0; p < 2; p++) begin
      issue(p[0], 1, 1);
      for (int k = 0; k < 20; k++) begin
        chk(armed && !pullup_on && !prog_on, "R10", {armed, pullup_on, prog_on}, 4);
        @(negedge clk);
      end
      fire = 1;
      @(negedge clk);
      fire = 0;
      chk(!armed, "R10", armed, 0);
      timed(p[0], 1, 0);
    end

    // R11: armed then cancelled
    issue(1, 0, 1);
    repeat (3) @(negedge clk);
    host_stop = 1;
    @(negedge clk);
    host_stop = 0;
    chk(!armed && !done, "R11", {armed, done}, 0);
    for (int k = 0; k < 10; k++) begin
      chk(!pullup_on && !prog_on && !done, "R11", {pullup_on, prog_on, done}, 0);
      @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule